// File: doc/BRIEF.md
# Branch Resolve and Static Predict Unit

This unit serves a simple 32-bit in-order pipeline at two points. In the fetch stage it looks at the kind of control-transfer instruction being fetched and its offset field. It then guesses whether control leaves the sequential path and produces the predicted next PC. Conditional branches are guessed from the sign of their offset alone: a backward branch is guessed taken and a forward branch is guessed not taken. PC-relative jumps are always guessed taken. Register-indirect jumps cannot be resolved at fetch, so they are guessed to fall through.

In the execute stage the unit resolves the instruction for real. It compares two register operands directly; no flags or carry are involved. It forms the actual target and decides taken or not. It compares that decision with the guess that travelled down the pipe and raises a one-cycle mispredict pulse with the corrected PC. For jumps it also produces the return address and a write request for a nonzero link register. It flags a taken target that is not word aligned.

Execute results are registered and appear one clock after the execute inputs are presented. Reset is asynchronous and active low, and its release is synchronised inside the block over two clock edges.

Top module: `bru_unit`

## Requirements
- R1: While reset is held and until the first execute instruction after release, o_mispredict, o_taken, o_link_we, o_misaligned are 0 and o_redirect_pc, o_link_val, o_link_rd are 0.
- R2: A branch (kind code 1) takes on condition code 0 when rs1 equals rs2, 1 when they differ, 4 when rs1 is less than rs2 as signed, 5 when rs1 is not signed-less than rs2, 6 when rs1 is less than rs2 as unsigned, 7 when rs1 is not unsigned-less than rs2; codes 2 and 3 never take.
- R3: A taken branch resolves to PC plus the sign-extended low 12 bits of the offset (a byte offset); a branch not taken resolves to PC plus 4.
- R4: At fetch, a branch whose offset bit 11 is 1 is predicted taken with the branch target as predicted PC; with bit 11 at 0 it is predicted not taken with PC plus 4.
- R5: A PC-relative jump (kind code 2) uses the 20-bit signed offset times 2 added to the PC, is always taken in execute, and at fetch is always predicted taken with that target.
- R6: A register-indirect jump (kind code 3) targets rs1 plus the sign-extended low 12 offset bits with bit 0 forced to 0, and is always taken in execute.
- R7: A jump of either kind with a nonzero link register number raises o_link_we with o_link_rd set to that number and o_link_val equal to PC plus 4; with link register 0 o_link_we stays 0.
- R8: o_mispredict pulses for one cycle exactly when the resolved taken decision differs from the x_pred_taken input, and o_redirect_pc then holds the resolved next PC (target if taken, PC plus 4 otherwise).
- R9: o_misaligned is 1 when the instruction resolves taken and its target bits 1:0 are not both 0.
- R10: When x_valid is 0, the next cycle shows no mispredict, no link write and no misaligned flag, and o_redirect_pc keeps its value.
- R11: At fetch, kind 0 (none) and kind 3 (register-indirect jump) are predicted not taken with PC plus 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| f_pc | input | 32 | PC of the instruction in fetch |
| f_kind | input | 2 | Fetch transfer kind: 0 none, 1 branch, 2 PC-relative jump, 3 indirect jump |
| f_off | input | 20 | Fetch offset field (branch uses bits 11:0) |
| f_pred_taken | output | 1 | Fetch prediction: taken |
| f_pred_pc | output | 32 | Fetch predicted next PC |
| x_valid | input | 1 | An instruction is present in execute |
| x_kind | input | 2 | Execute transfer kind, same codes as f_kind |
| x_cond | input | 3 | Branch condition code |
| x_pc | input | 32 | PC of the instruction in execute |
| x_off | input | 20 | Execute offset field |
| x_rs1 | input | 32 | First register operand / indirect base |
| x_rs2 | input | 32 | Second register operand |
| x_rd | input | 5 | Link register number |
| x_pred_taken | input | 1 | Prediction made at fetch for this instruction |
| o_mispredict | output | 1 | Resolved decision differs from prediction |
| o_redirect_pc | output | 32 | Resolved next PC |
| o_taken | output | 1 | Resolved taken |
| o_link_we | output | 1 | Write return address to link register |
| o_link_rd | output | 5 | Link register number |
| o_link_val | output | 32 | Return address |
| o_misaligned | output | 1 | Taken target not word aligned |

## Verification
The assertions watch, on every cycle, the properties that hold whatever the operands are. A link write never targets register 0 and always carries the PC plus 4 of the jump that caused it. An idle execute slot leaves no mispredict, link write or misaligned flag. An indirect jump never produces an odd redirect. A misaligned flag only comes with a taken, misaligned redirect. A PC-relative jump at fetch is always guessed taken. Whether each of the six conditions decides correctly across signed and unsigned corner values, the exact target arithmetic, the sign-bit prediction, and the mispredict pulse against a correct or wrong guess can only be shown by the directed scenarios with their computed expected values.

// File: rtl/bru_pkg.sv
package bru_pkg;
  localparam logic [1:0] KIND_NONE   = 2'd0;
  localparam logic [1:0] KIND_BRANCH = 2'd1;
  localparam logic [1:0] KIND_JAL    = 2'd2;
  localparam logic [1:0] KIND_JALR   = 2'd3;

  localparam logic [2:0] COND_EQ  = 3'd0;
  localparam logic [2:0] COND_NE  = 3'd1;
  localparam logic [2:0] COND_LT  = 3'd4;
  localparam logic [2:0] COND_GE  = 3'd5;
  localparam logic [2:0] COND_LTU = 3'd6;
  localparam logic [2:0] COND_GEU = 3'd7;
endpackage

// File: rtl/bru_compare.sv
module bru_compare
  import bru_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [2:0]      cond,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic            hit
);
  logic is_eq;
  logic lt_s;
  logic lt_u;

  always_comb begin
    is_eq = (opa == opb);
    lt_s  = ($signed(opa) < $signed(opb));
    lt_u  = (opa < opb);
    case (cond)
      COND_EQ:  hit = is_eq;
      COND_NE:  hit = !is_eq;
      COND_LT:  hit = lt_s;
      COND_GE:  hit = !lt_s;
      COND_LTU: hit = lt_u;
      COND_GEU: hit = !lt_u;
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/bru_target.sv
module bru_target
  import bru_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int BOFF_W = 12,
  parameter int JOFF_W = 20
) (
  input  logic [1:0]        kind,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   base,
  input  logic [JOFF_W-1:0] off,
  output logic [XLEN-1:0]   target,
  output logic [XLEN-1:0]   seq_pc
);
  localparam int BEXT = XLEN - BOFF_W;
  localparam int JEXT = XLEN - JOFF_W - 1;

  logic [XLEN-1:0] short_ext;
  logic [XLEN-1:0] long_ext;
  logic [XLEN-1:0] ind_sum;

  always_comb begin
    short_ext = {{BEXT{off[BOFF_W-1]}}, off[BOFF_W-1:0]};
    long_ext  = {{JEXT{off[JOFF_W-1]}}, off, 1'b0};
    seq_pc    = pc + XLEN'(4);
    ind_sum   = base + short_ext;
    case (kind)
      KIND_BRANCH: target = pc + short_ext;
      KIND_JAL:    target = pc + long_ext;
      KIND_JALR:   target = {ind_sum[XLEN-1:1], 1'b0};
      default:     target = seq_pc;
    endcase
  end
endmodule

// File: rtl/bru_predict.sv
module bru_predict
  import bru_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [1:0]      kind,
  input  logic            off_sign,
  input  logic [XLEN-1:0] target,
  input  logic [XLEN-1:0] seq_pc,
  output logic            pred_taken,
  output logic [XLEN-1:0] pred_pc
);
  always_comb begin
    case (kind)
      KIND_BRANCH: pred_taken = off_sign;
      KIND_JAL:    pred_taken = 1'b1;
      default:     pred_taken = 1'b0;
    endcase
    pred_pc = pred_taken ? target : seq_pc;
  end
endmodule

// File: rtl/bru_unit.sv
module bru_unit
  import bru_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int BOFF_W = 12,
  parameter int JOFF_W = 20,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   f_pc,
  input  logic [1:0]        f_kind,
  input  logic [JOFF_W-1:0] f_off,
  output logic              f_pred_taken,
  output logic [XLEN-1:0]   f_pred_pc,
  input  logic              x_valid,
  input  logic [1:0]        x_kind,
  input  logic [2:0]        x_cond,
  input  logic [XLEN-1:0]   x_pc,
  input  logic [JOFF_W-1:0] x_off,
  input  logic [XLEN-1:0]   x_rs1,
  input  logic [XLEN-1:0]   x_rs2,
  input  logic [REG_W-1:0]  x_rd,
  input  logic              x_pred_taken,
  output logic              o_mispredict,
  output logic [XLEN-1:0]   o_redirect_pc,
  output logic              o_taken,
  output logic              o_link_we,
  output logic [REG_W-1:0]  o_link_rd,
  output logic [XLEN-1:0]   o_link_val,
  output logic              o_misaligned
);
  localparam int SYNC_STAGES = 2;

  // reset release synchroniser
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  // fetch side
  logic [XLEN-1:0] f_target;
  logic [XLEN-1:0] f_seq;

  bru_target #(.XLEN(XLEN), .BOFF_W(BOFF_W), .JOFF_W(JOFF_W)) i_f_target (
    .kind(f_kind), .pc(f_pc), .base(f_pc), .off(f_off),
    .target(f_target), .seq_pc(f_seq)
  );

  bru_predict #(.XLEN(XLEN)) i_predict (
    .kind(f_kind), .off_sign(f_off[BOFF_W-1]), .target(f_target),
    .seq_pc(f_seq), .pred_taken(f_pred_taken), .pred_pc(f_pred_pc)
  );

  // a PC-relative jump is never guessed to fall through
  assert_jal_guessed_taken_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (f_kind == KIND_JAL) |-> f_pred_taken);

  // execute side
  logic [XLEN-1:0] x_target;
  logic [XLEN-1:0] x_seq;
  logic            cond_hit;

  bru_target #(.XLEN(XLEN), .BOFF_W(BOFF_W), .JOFF_W(JOFF_W)) i_x_target (
    .kind(x_kind), .pc(x_pc), .base(x_rs1), .off(x_off),
    .target(x_target), .seq_pc(x_seq)
  );

  bru_compare #(.XLEN(XLEN)) i_compare (
    .cond(x_cond), .opa(x_rs1), .opb(x_rs2), .hit(cond_hit)
  );

  logic            is_jump;
  logic            d_taken;
  logic            d_mispredict;
  logic            d_link_we;
  logic            d_misaligned;
  logic [XLEN-1:0] d_next_pc;

  always_comb begin
    is_jump      = (x_kind == KIND_JAL) || (x_kind == KIND_JALR);
    d_taken      = x_valid && (is_jump || ((x_kind == KIND_BRANCH) && cond_hit));
    d_next_pc    = d_taken ? x_target : x_seq;
    d_mispredict = x_valid && (d_taken != x_pred_taken);
    d_link_we    = x_valid && is_jump && (x_rd != '0);
    d_misaligned = d_taken && (x_target[1:0] != 2'b00);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      o_mispredict  <= 1'b0;
      o_taken       <= 1'b0;
      o_link_we     <= 1'b0;
      o_misaligned  <= 1'b0;
      o_redirect_pc <= '0;
      o_link_rd     <= '0;
      o_link_val    <= '0;
    end else begin
      o_mispredict <= d_mispredict;
      o_taken      <= d_taken;
      o_link_we    <= d_link_we;
      o_misaligned <= d_misaligned;
      if (x_valid) begin
        o_redirect_pc <= d_next_pc;
        o_link_rd     <= x_rd;
        o_link_val    <= x_seq;
      end
    end
  end

  assert_link_not_zero_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    o_link_we |-> (o_link_rd != '0));

  assert_link_value_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (x_valid && (x_kind == KIND_JAL || x_kind == KIND_JALR) && x_rd != '0)
    |=> (o_link_we && o_link_val == $past(x_pc) + XLEN'(4)));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !x_valid |=> (!o_mispredict && !o_link_we && !o_misaligned && $stable(o_redirect_pc)));

  assert_misaligned_taken_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    o_misaligned |-> (o_taken && o_redirect_pc[1:0] != 2'b00));

  assert_indirect_even_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (x_valid && x_kind == KIND_JALR) |=> (o_taken && !o_redirect_pc[0]));
endmodule

// File: tb/test_bru_unit.sv
`timescale 1ns/1ps
module test_bru_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] f_pc;
  logic [1:0]  f_kind;
  logic [19:0] f_off;
  logic        f_pred_taken;
  logic [31:0] f_pred_pc;
  logic        x_valid;
  logic [1:0]  x_kind;
  logic [2:0]  x_cond;
  logic [31:0] x_pc;
  logic [19:0] x_off;
  logic [31:0] x_rs1;
  logic [31:0] x_rs2;
  logic [4:0]  x_rd;
  logic        x_pred_taken;
  logic        o_mispredict;
  logic [31:0] o_redirect_pc;
  logic        o_taken;
  logic        o_link_we;
  logic [4:0]  o_link_rd;
  logic [31:0] o_link_val;
  logic        o_misaligned;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bru_unit i_bru_unit (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sx12(input logic [19:0] o);
    return {{20{o[11]}}, o[11:0]};
  endfunction

  function automatic bit cond_model(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b);
    case (c)
      3'd0: return a == b;
      3'd1: return a != b;
      3'd4: return $signed(a) < $signed(b);
      3'd5: return $signed(a) >= $signed(b);
      3'd6: return a < b;
      3'd7: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  // present one execute instruction, results visible after the next edge
  task automatic exec(input logic [1:0] k, input logic [2:0] c, input logic [31:0] pc,
                      input logic [19:0] off, input logic [31:0] a, input logic [31:0] b,
                      input logic [4:0] rd, input logic pt);
    x_valid = 1'b1; x_kind = k; x_cond = c; x_pc = pc; x_off = off;
    x_rs1 = a; x_rs2 = b; x_rd = rd; x_pred_taken = pt;
    @(posedge clk); #2;
    x_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; x_valid = 1'b0; x_kind = 2'd0; x_cond = 3'd0; x_pc = '0; x_off = '0;
    x_rs1 = '0; x_rs2 = '0; x_rd = '0; x_pred_taken = 1'b0;
    f_pc = '0; f_kind = 2'd0; f_off = '0;
    repeat (3) @(posedge clk); #2;
    check("R1 mispredict", {31'd0, o_mispredict}, 32'd0);
    check("R1 redirect", o_redirect_pc, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk); #2;
    check("R1 flags", {28'd0, o_taken, o_link_we, o_misaligned, o_mispredict}, 32'd0);
    check("R1 link", o_link_val | {27'd0, o_link_rd}, 32'd0);
  endtask

  task automatic t_conditions;
    logic [31:0] av [4] = '{32'd7, 32'hFFFF_FFFE, 32'd3, 32'h8000_0000};
    logic [31:0] bv [4] = '{32'd7, 32'd5, 32'hFFFF_FFF0, 32'h7FFF_FFFF};
    logic [2:0]  cv [8] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 8; c++) begin
        exec(2'd1, cv[c], 32'h0000_1000, 20'h00010, av[p], bv[p], 5'd0, 1'b0);
        check($sformatf("R2 cond %0d pair %0d", c, p), {31'd0, o_taken},
              {31'd0, cond_model(cv[c], av[p], bv[p])});
      end
    end
  endtask

  task automatic t_branch_target;
    // backward branch taken, guessed taken: no mispredict
    exec(2'd1, 3'd0, 32'h0000_2000, 20'h00FF0, 32'd1, 32'd1, 5'd0, 1'b1);
    check("R3 backward target", o_redirect_pc, 32'h0000_2000 + sx12(20'h00FF0));
    check("R8 correct guess", {31'd0, o_mispredict}, 32'd0);
    // branch not taken but guessed taken: mispredict to PC+4
    exec(2'd1, 3'd1, 32'h0000_2000, 20'h00FF0, 32'd1, 32'd1, 5'd0, 1'b1);
    check("R3 fallthrough", o_redirect_pc, 32'h0000_2004);
    check("R8 wrong guess nt", {31'd0, o_mispredict}, 32'd1);
    // forward taken, guessed not taken
    exec(2'd1, 3'd6, 32'h0000_3000, 20'h00124, 32'd2, 32'd9, 5'd0, 1'b0);
    check("R3 forward target", o_redirect_pc, 32'h0000_3124);
    check("R8 wrong guess t", {31'd0, o_mispredict}, 32'd1);
    // one idle cycle: pulse gone
    @(posedge clk); #2;
    check("R8 pulse one cycle", {31'd0, o_mispredict}, 32'd0);
  endtask

  task automatic t_fetch;
    f_pc = 32'h0000_4000; f_kind = 2'd1; f_off = 20'h00FF8; #1;
    check("R4 backward guess", {31'd0, f_pred_taken}, 32'd1);
    check("R4 backward pc", f_pred_pc, 32'h0000_4000 + sx12(20'h00FF8));
    f_off = 20'h007F8; #1;
    check("R4 forward guess", {f_pred_pc[31:1], f_pred_taken}, {31'h0000_2002, 1'b0});
    f_kind = 2'd2; f_off = 20'hFFFFE; #1;
    check("R5 fetch jal", f_pred_pc, 32'h0000_4000 - 32'd4);
    check("R5 fetch jal taken", {31'd0, f_pred_taken}, 32'd1);
    f_kind = 2'd3; #1;
    check("R11 fetch indirect", f_pred_pc, 32'h0000_4004);
    f_kind = 2'd0; f_off = 20'h00FF8; #1;
    check("R11 fetch none", {f_pred_pc[31:1], f_pred_taken}, {31'h0000_2002, 1'b0});
  endtask

  task automatic t_jal;
    exec(2'd2, 3'd0, 32'h0001_0000, 20'h00100, 32'd0, 32'd0, 5'd1, 1'b1);
    check("R5 jal target", o_redirect_pc, 32'h0001_0200);
    check("R5 jal no mispredict", {31'd0, o_mispredict}, 32'd0);
    check("R7 link write", {26'd0, o_link_we, o_link_rd}, {26'd0, 1'b1, 5'd1});
    check("R7 link value", o_link_val, 32'h0001_0004);
    exec(2'd2, 3'd0, 32'h0001_0000, 20'h00100, 32'd0, 32'd0, 5'd0, 1'b1);
    check("R7 rd zero discards", {31'd0, o_link_we}, 32'd0);
  endtask

  task automatic t_jalr;
    exec(2'd3, 3'd0, 32'h0000_5000, 20'h00005, 32'h0000_8000, 32'd0, 5'd5, 1'b0);
    check("R6 indirect target", o_redirect_pc, 32'h0000_8004);
    check("R6 indirect taken", {30'd0, o_taken, o_mispredict}, 32'd3);
    check("R9 aligned ok", {31'd0, o_misaligned}, 32'd0);
    exec(2'd3, 3'd0, 32'h0000_5000, 20'h00FFE, 32'h0000_8000, 32'd0, 5'd0, 1'b0);
    check("R9 misaligned", {31'd0, o_misaligned}, 32'd1);
    check("R6 negative offset", o_redirect_pc, 32'h0000_7FFE);
    exec(2'd1, 3'd1, 32'h0000_6000, 20'h00002, 32'd1, 32'd1, 5'd0, 1'b0);
    check("R9 not taken no flag", {31'd0, o_misaligned}, 32'd0);
  endtask

  task automatic t_idle;
    logic [31:0] held;
    held = o_redirect_pc;
    x_valid = 1'b0; x_kind = 2'd2; x_rd = 5'd3; x_pc = 32'h0000_9000;
    x_off = 20'h00001; x_pred_taken = 1'b0;
    @(posedge clk); #2;
    check("R10 idle flags", {29'd0, o_mispredict, o_link_we, o_misaligned}, 32'd0);
    check("R10 redirect held", o_redirect_pc, held);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_conditions();
    t_branch_target();
    t_fetch();
    t_jal();
    t_jalr();
    t_idle();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule